// File: doc/BRIEF.md
# Fractional PLL Coefficient Calculator

This block turns a requested pixel clock into the divider settings of a fractional-N PLL. All frequencies are unsigned integers in kHz: the reference clock, the target clock, the highest VCO frequency and the highest frequency allowed at the VCO input. Two more inputs give the lowest and highest allowed post divider. From these the block computes four results: the post divider P, the reference divider M, the integer feedback divider N and a signed fractional feedback word fN centred on zero. It also reports the achieved clock and packs the results into two control-register words. The mode word that goes with them is a constant.

A caller applies the operands and pulses `start`. The block captures the operands and runs three divisions in turn on one shared restoring divider, which produces one quotient bit per cycle. The feedback ratio is held in fixed point with 12 fraction bits, and the multiply-before-divide intermediate is wide enough that it cannot overflow. When every result is ready, `done` pulses for one cycle. Operands that would divide by zero are rejected at once and flagged with `err`.

Top module: `frac_pll_calc`

## Requirements
- R1: P is the integer quotient of `vco_max_khz / tgt_khz`. It is first limited to at most `p_hi`, then raised to at least `p_lo`, so `p_lo` wins when `p_lo > p_hi`.
- R2: M is the ceiling of `ref_khz / vin_max_khz`, reported in its low 8 bits.
- R3: The feedback ratio is floor(tgt_khz × P × M × 4096 / ref_khz), using the 8-bit M and computed exactly for any 32-bit inputs. N is bits 19:12 of this ratio.
- R4: fN is 2 × (ratio mod 4096) − 4096 as a 16-bit two's-complement word. It is always even and lies in −4096..4094.
- R5: `clk_achieved` equals the captured target clock after a successful run.
- R6: `ctl_word0` holds `ctl0_keep` in bits 31:22, P in bits 21:16, M in bits 15:8 and N in bits 7:0. `ctl_word1` holds fN in bits 15:0 and zeros above. `mode_word` is 0x50000610 at all times.
- R7: If a start arrives while `tgt_khz`, `ref_khz` or `vin_max_khz` is zero, `done` and `err` are high one cycle later and every result output is zero. `err` then stays high until the next accepted start.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start until `done`. Results hold their values until the next completion.
- R9: Operands are captured at the accepted start. Changing them, or pulsing `start` again while `busy` is high, has no effect on the running computation.
- R10: After reset, `done`, `err` and `busy` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (ignored while busy) |
| ref_khz | input | 32 | Reference clock, kHz |
| tgt_khz | input | 32 | Requested clock, kHz |
| vco_max_khz | input | 32 | Highest VCO frequency, kHz |
| vin_max_khz | input | 32 | Highest VCO input frequency, kHz |
| p_lo | input | 6 | Lowest allowed post divider |
| p_hi | input | 6 | Highest allowed post divider |
| ctl0_keep | input | 10 | Current bits 31:22 of the first control word, carried through |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | Last start was rejected for a zero operand |
| p_div | output | 6 | Post divider P |
| m_div | output | 8 | Reference divider M |
| n_div | output | 8 | Integer feedback divider N |
| fn_word | output | 16 | Signed fractional feedback word |
| clk_achieved | output | 32 | Reported achieved clock, kHz |
| ctl_word0 | output | 32 | Packed P/M/N control word |
| ctl_word1 | output | 32 | Packed fractional control word |
| mode_word | output | 32 | Constant mode/control word |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse and never coincides with `busy`. At each completion they also check that P lies within the captured limits, that fN is even and inside its range, that the packed word agrees with the individual fields, and that a rejected start leaves only zeros. The divider's remainder staying below its divisor is checked on every cycle as well. Only the bench's scenarios can show that the quotients themselves are right: the clamping in both directions, the ceiling on M, exact integer ratios, truncation of N and targets near 1 GHz. The bench scenarios also cover the capture of operands against later changes, the rejection of each zero operand, and the way results hold between runs.

// File: rtl/fpll_pkg.sv
`timescale 1ns/1ps
package fpll_pkg;
   // sequencing of the shared divider
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PDIV = 2'd1,
      ST_MDIV = 2'd2,
      ST_RDIV = 2'd3
   } calc_st_t;

   localparam int FRAC_BITS = 12;
   localparam int FN_W      = 16;

   // field layout of the first control word
   localparam int N_LSB   = 0;
   localparam int N_FLD_W = 8;
   localparam int M_LSB   = 8;
   localparam int M_FLD_W = 8;
   localparam int P_LSB   = 16;
   localparam int P_FLD_W = 6;
   localparam int KEEP_LSB = 22;
   localparam int KEEP_W   = 10;

   localparam logic [31:0] MODE_WORD = 32'h5000_0610;
endpackage

// File: rtl/fpll_divider.sv
`timescale 1ns/1ps
module fpll_divider #(
   parameter int DW = 58,
   parameter int VW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] dividend,
   input  logic [VW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quot
);
   localparam int CW = $clog2(DW + 1);

   if (DW < 2) begin : g_bad_dw
      $error("fpll_divider: DW must be at least 2");
   end
   if (VW < 1) begin : g_bad_vw
      $error("fpll_divider: VW must be at least 1");
   end

   logic [DW-1:0] acc;
   logic [VW-1:0] rem;
   logic [VW-1:0] dvs;
   logic [CW-1:0] cnt;
   logic          run;
   logic          done_q;

   logic [VW:0]   trial;
   logic [VW:0]   diff;
   logic          ge;
   logic [VW-1:0] rem_nx;

   always_comb begin
      trial  = {rem, acc[DW-1]};
      ge     = (trial >= {1'b0, dvs});
      diff   = trial - {1'b0, dvs};
      rem_nx = ge ? diff[VW-1:0] : trial[VW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         rem    <= '0;
         dvs    <= '0;
         cnt    <= '0;
         run    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go && !run) begin
            acc <= dividend;
            rem <= '0;
            dvs <= divisor;
            cnt <= CW'(DW);
            run <= 1'b1;
         end else if (run) begin
            acc <= {acc[DW-2:0], ge};
            rem <= rem_nx;
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run    <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy = run;
   assign done = done_q;
   assign quot = acc;

   // partial remainder of a restoring divider never reaches the divisor (R3)
   p_rem_below_dvs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && dvs != '0) |-> (rem < dvs));

   // completion flag is a single pulse (R8)
   p_div_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/fpll_pack.sv
`timescale 1ns/1ps
module fpll_pack
   import fpll_pkg::*;
#(
   parameter int PW = 6,
   parameter int MW = 8,
   parameter int NW = 8
) (
   input  logic [KEEP_W-1:0] keep,
   input  logic [PW-1:0]     p,
   input  logic [MW-1:0]     m,
   input  logic [NW-1:0]     n,
   input  logic [FN_W-1:0]   fn,
   output logic [31:0]       word0,
   output logic [31:0]       word1
);
   if (PW > P_FLD_W) begin : g_bad_pw
      $error("fpll_pack: P wider than its field");
   end
   if (MW > M_FLD_W) begin : g_bad_mw
      $error("fpll_pack: M wider than its field");
   end
   if (NW > N_FLD_W) begin : g_bad_nw
      $error("fpll_pack: N wider than its field");
   end

   always_comb begin
      word0 = '0;
      word0[KEEP_LSB +: KEEP_W] = keep;
      word0[P_LSB +: PW]        = p;
      word0[M_LSB +: MW]        = m;
      word0[N_LSB +: NW]        = n;
      word1 = '0;
      word1[FN_W-1:0] = fn;
   end
endmodule

// File: rtl/frac_pll_calc.sv
`timescale 1ns/1ps
module frac_pll_calc
   import fpll_pkg::*;
#(
   parameter int CLK_W = 32,
   parameter int PW    = 6,
   parameter int MW    = 8,
   parameter int NW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CLK_W-1:0]  ref_khz,
   input  logic [CLK_W-1:0]  tgt_khz,
   input  logic [CLK_W-1:0]  vco_max_khz,
   input  logic [CLK_W-1:0]  vin_max_khz,
   input  logic [PW-1:0]     p_lo,
   input  logic [PW-1:0]     p_hi,
   input  logic [KEEP_W-1:0] ctl0_keep,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [PW-1:0]     p_div,
   output logic [MW-1:0]     m_div,
   output logic [NW-1:0]     n_div,
   output logic [FN_W-1:0]   fn_word,
   output logic [CLK_W-1:0]  clk_achieved,
   output logic [31:0]       ctl_word0,
   output logic [31:0]       ctl_word1,
   output logic [31:0]       mode_word
);
   // product tgt*P*M shifted by the fraction width: exact, never overflows
   localparam int DW = CLK_W + PW + MW + FRAC_BITS;
   localparam logic [FN_W-1:0] FN_OFS = FN_W'(1 << FRAC_BITS);

   if (DW < 48) begin : g_bad_dw
      $error("frac_pll_calc: intermediate narrower than 48 bits");
   end
   if (FRAC_BITS + 1 >= FN_W) begin : g_bad_fn
      $error("frac_pll_calc: fraction word too narrow");
   end

   calc_st_t st;
   logic     go_q;

   logic [CLK_W-1:0]  ref_l, tgt_l, vco_l, vin_l;
   logic [PW-1:0]     p_lo_l, p_hi_l;
   logic [KEEP_W-1:0] keep_l;
   logic [PW-1:0]     p_r;
   logic [MW-1:0]     m_r;

   logic [DW-1:0]     dvd;
   logic [CLK_W-1:0]  dvs;
   logic [DW-1:0]     prod;
   logic [DW-1:0]     dq;
   logic              d_busy, d_done;

   logic [PW-1:0]     p_sel;
   logic [NW-1:0]     n_fin;
   logic [FN_W-1:0]   fn_fin;
   logic [31:0]       w0_fin, w1_fin;
   logic              zero_op;

   assign zero_op = (ref_khz == '0) || (tgt_khz == '0) || (vin_max_khz == '0);

   // operand selection for the shared divider
   always_comb begin
      prod = DW'(tgt_l) * DW'(p_r) * DW'(m_r);
      case (st)
         ST_PDIV: begin
            dvd = DW'(vco_l);
            dvs = tgt_l;
         end
         ST_MDIV: begin
            dvd = DW'(ref_l) + DW'(vin_l) - DW'(1);
            dvs = vin_l;
         end
         default: begin
            dvd = prod << FRAC_BITS;
            dvs = ref_l;
         end
      endcase
   end

   fpll_divider #(.DW(DW), .VW(CLK_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go_q),
      .dividend (dvd),
      .divisor  (dvs),
      .busy     (d_busy),
      .done     (d_done),
      .quot     (dq)
   );

   // clamp: upper limit first, lower limit last
   always_comb begin
      if (dq > DW'(p_hi_l)) p_sel = p_hi_l;
      else                  p_sel = dq[PW-1:0];
      if (p_sel < p_lo_l)   p_sel = p_lo_l;
   end

   always_comb begin
      n_fin  = dq[FRAC_BITS +: NW];
      fn_fin = FN_W'({dq[FRAC_BITS-1:0], 1'b0}) - FN_OFS;
   end

   fpll_pack #(.PW(PW), .MW(MW), .NW(NW)) u_pack (
      .keep  (keep_l),
      .p     (p_r),
      .m     (m_r),
      .n     (n_fin),
      .fn    (fn_fin),
      .word0 (w0_fin),
      .word1 (w1_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         go_q         <= 1'b0;
         done         <= 1'b0;
         err          <= 1'b0;
         ref_l        <= '0;
         tgt_l        <= '0;
         vco_l        <= '0;
         vin_l        <= '0;
         p_lo_l       <= '0;
         p_hi_l       <= '0;
         keep_l       <= '0;
         p_r          <= '0;
         m_r          <= '0;
         p_div        <= '0;
         m_div        <= '0;
         n_div        <= '0;
         fn_word      <= '0;
         clk_achieved <= '0;
         ctl_word0    <= '0;
         ctl_word1    <= '0;
      end else begin
         go_q <= 1'b0;
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  if (zero_op) begin
                     done         <= 1'b1;
                     err          <= 1'b1;
                     p_div        <= '0;
                     m_div        <= '0;
                     n_div        <= '0;
                     fn_word      <= '0;
                     clk_achieved <= '0;
                     ctl_word0    <= '0;
                     ctl_word1    <= '0;
                  end else begin
                     err    <= 1'b0;
                     ref_l  <= ref_khz;
                     tgt_l  <= tgt_khz;
                     vco_l  <= vco_max_khz;
                     vin_l  <= vin_max_khz;
                     p_lo_l <= p_lo;
                     p_hi_l <= p_hi;
                     keep_l <= ctl0_keep;
                     go_q   <= 1'b1;
                     st     <= ST_PDIV;
                  end
               end
            end
            ST_PDIV: begin
               if (d_done) begin
                  p_r  <= p_sel;
                  go_q <= 1'b1;
                  st   <= ST_MDIV;
               end
            end
            ST_MDIV: begin
               if (d_done) begin
                  m_r  <= dq[MW-1:0];
                  go_q <= 1'b1;
                  st   <= ST_RDIV;
               end
            end
            default: begin
               if (d_done) begin
                  p_div        <= p_r;
                  m_div        <= m_r;
                  n_div        <= n_fin;
                  fn_word      <= fn_fin;
                  clk_achieved <= tgt_l;
                  ctl_word0    <= w0_fin;
                  ctl_word1    <= w1_fin;
                  done         <= 1'b1;
                  st           <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign mode_word = MODE_WORD;

   // P inside the captured limits whenever the limits are ordered (R1)
   p_p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && p_lo_l <= p_hi_l) |-> (p_div >= p_lo_l && p_div <= p_hi_l));

   // fractional word is even and within -4096..4094 (R4)
   p_fn_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (!fn_word[0] &&
         ($signed(fn_word) >= -$signed(FN_OFS)) && ($signed(fn_word) < $signed(FN_OFS))));

   // achieved clock tracks the captured request (R5)
   p_clk_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (clk_achieved == tgt_l));

   // packed word agrees with the separate fields (R6)
   p_word_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (ctl_word0[P_LSB +: PW] == p_div &&
                          ctl_word0[M_LSB +: MW] == m_div &&
                          ctl_word0[N_LSB +: NW] == n_div &&
                          ctl_word1[FN_W-1:0]    == fn_word));

   // rejected start leaves only zeros (R7)
   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (p_div == '0 && m_div == '0 && n_div == '0 &&
                         fn_word == '0 && ctl_word0 == '0 && ctl_word1 == '0));

   // single-cycle completion, never while busy (R8)
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/tb_frac_pll_calc.sv
`timescale 1ns/1ps
module tb_frac_pll_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ref_khz = '0, tgt_khz = '0, vco_max_khz = '0, vin_max_khz = '0;
   logic [5:0]  p_lo = '0, p_hi = '0;
   logic [9:0]  ctl0_keep = '0;
   logic        busy, done, err;
   logic [5:0]  p_div;
   logic [7:0]  m_div, n_div;
   logic [15:0] fn_word;
   logic [31:0] clk_achieved, ctl_word0, ctl_word1, mode_word;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   frac_pll_calc dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ref_khz(ref_khz), .tgt_khz(tgt_khz), .vco_max_khz(vco_max_khz),
      .vin_max_khz(vin_max_khz), .p_lo(p_lo), .p_hi(p_hi), .ctl0_keep(ctl0_keep),
      .busy(busy), .done(done), .err(err), .p_div(p_div), .m_div(m_div),
      .n_div(n_div), .fn_word(fn_word), .clk_achieved(clk_achieved),
      .ctl_word0(ctl_word0), .ctl_word1(ctl_word1), .mode_word(mode_word)
   );

   // stimulus table: ref, tgt, vco max, vin max, p_lo, p_hi, keep bits
   localparam int NV = 9;
   localparam int unsigned T_REF [NV] = '{27000, 27000, 100000, 100001, 27000, 10000, 27000, 3, 27000};
   localparam int unsigned T_TGT [NV] = '{148500, 25175, 65000, 65000, 1000000, 5000, 108000, 1000, 74250};
   localparam int unsigned T_VCO [NV] = '{1400000, 800000, 400000, 400000, 2000000, 1000000, 500000, 60000, 1000000};
   localparam int unsigned T_VIN [NV] = '{40000, 27000, 25000, 25000, 27000, 10000, 14000, 1, 30000};
   localparam int unsigned T_PLO [NV] = '{1, 1, 8, 2, 1, 10, 1, 1, 1};
   localparam int unsigned T_PHI [NV] = '{7, 63, 20, 20, 4, 3, 15, 63, 63};
   localparam int unsigned T_KEEP[NV] = '{1023, 291, 0, 682, 341, 1, 512, 77, 960};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model(
      input  longint unsigned r, t, v, vi, pl, ph,
      input  logic [9:0]  keep,
      output logic [5:0]  ep,
      output logic [7:0]  em,
      output logic [7:0]  en,
      output logic [15:0] efn,
      output logic [31:0] ew0,
      output logic [31:0] ew1);
      longint unsigned p0, m0, ratio, pp, mm;
      p0 = v / t;
      if (p0 > ph) p0 = ph;
      if (p0 < pl) p0 = pl;
      ep = p0[5:0];
      m0 = (r + vi - 1) / vi;
      em = m0[7:0];
      pp = longint'(ep);
      mm = longint'(em);
      ratio = (t * pp * mm * 4096) / r;
      en  = 8'(ratio >> 12);
      efn = 16'({ratio[11:0], 1'b0}) - 16'h1000;
      ew0 = {keep, ep, em, en};
      ew1 = {16'h0000, efn};
   endfunction

   task automatic apply(input int unsigned r, t, v, vi, pl, ph, kp);
      ref_khz = r; tgt_khz = t; vco_max_khz = v; vin_max_khz = vi;
      p_lo = 6'(pl); p_hi = 6'(ph); ctl0_keep = 10'(kp);
   endtask

   // waits from the negedge after start for done; leaves time at that negedge
   task automatic wait_done(output bit ok);
      int n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      ok = done;
      if (!ok) begin
         total++; bad++;
         $display("FAIL R8 actual=no_done expected=done");
      end
   endtask

   task automatic check_results(input int idx, input string tag);
      logic [5:0] ep; logic [7:0] em, en; logic [15:0] efn; logic [31:0] ew0, ew1;
      model(T_REF[idx], T_TGT[idx], T_VCO[idx], T_VIN[idx], T_PLO[idx], T_PHI[idx],
            10'(T_KEEP[idx]), ep, em, en, efn, ew0, ew1);
      chk({tag, " R1 p"},   p_div, ep);
      chk({tag, " R2 m"},   m_div, em);
      chk({tag, " R3 n"},   n_div, en);
      chk({tag, " R4 fn"},  fn_word, efn);
      chk({tag, " R5 clk"}, clk_achieved, T_TGT[idx]);
      chk({tag, " R6 w0"},  ctl_word0, ew0);
      chk({tag, " R6 w1"},  ctl_word1, ew1);
      chk({tag, " R7 err"}, err, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit ok;
      logic [5:0] hp;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 done", done, 0);
      chk("R10 err", err, 0);
      chk("R10 busy", busy, 0);
      chk("R10 p", p_div, 0);
      chk("R10 w0", ctl_word0, 0);
      chk("R10 fn", fn_word, 0);
      chk("R6 mode in reset", mode_word, 32'h5000_0610);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(T_REF[i], T_TGT[i], T_VCO[i], T_VIN[i], T_PLO[i], T_PHI[i], T_KEEP[i]);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R8 busy after start", busy, 1);
         wait_done(ok);
         if (ok) begin
            check_results(i, $sformatf("vec%0d", i));
            hp = p_div;
            @(negedge clk);
            chk("R8 done pulse", done, 0);
            chk("R8 hold p", p_div, hp);
            chk("R8 idle", busy, 0);
         end
      end
      chk("R6 mode", mode_word, 32'h5000_0610);

      // R9: operands changed and start re-pulsed while busy
      apply(T_REF[2], T_TGT[2], T_VCO[2], T_VIN[2], T_PLO[2], T_PHI[2], T_KEEP[2]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      apply(T_REF[3], T_TGT[3], T_VCO[3], T_VIN[3], T_PLO[3], T_PHI[3], T_KEEP[3]);
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      apply(0, 0, 0, 0, 0, 0, 0);
      wait_done(ok);
      if (ok) begin
         check_results(2, "R9 capture");
         @(negedge clk);
         chk("R9 no second run", busy, 0);
         repeat (200) @(negedge clk);
         chk("R9 no late done", done, 0);
      end

      // R7: each zero operand rejected one cycle after start
      for (int k = 0; k < 3; k++) begin
         apply(T_REF[0], T_TGT[0], T_VCO[0], T_VIN[0], T_PLO[0], T_PHI[0], T_KEEP[0]);
         if (k == 0) tgt_khz = 0;
         if (k == 1) ref_khz = 0;
         if (k == 2) vin_max_khz = 0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R7 done next cycle", done, 1);
         chk("R7 err", err, 1);
         chk("R7 zero p", p_div, 0);
         chk("R7 zero n", n_div, 0);
         chk("R7 zero fn", fn_word, 0);
         chk("R7 zero clk", clk_achieved, 0);
         chk("R7 zero w0", ctl_word0, 0);
         chk("R7 not busy", busy, 0);
         @(negedge clk);
         chk("R7 err held", err, 1);
         chk("R8 err done pulse", done, 0);
      end

      // R7: a good start clears the error
      apply(T_REF[8], T_TGT[8], T_VCO[8], T_VIN[8], T_PLO[8], T_PHI[8], T_KEEP[8]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      if (ok) check_results(8, "R7 recover");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule